// File: doc/BRIEF.md
# Clock-chip host register file and interrupt controller

This block is the host-side register file of a real-time clock. The host reaches it through two addresses. A write to the even address selects an index. An access to the odd address then reads or writes the selected byte of a 128-byte store. The store holds the current seconds, minutes and hours, the three alarm bytes, the calendar bytes, four control bytes and general-purpose memory.

Separate blocks count time and generate the periodic rate. They connect to this block as follows:
- The time counter signals the start of each once-per-second update with a strobe. It also presents the new seconds, minutes and hours bytes, already in the encoding that control byte B selects.
- A 32768 Hz tick strobe times the update window.
- A periodic strobe reports each periodic event.

This block maintains the update-in-progress flag and the set-mode rules. At the end of every update it latches the new time, compares it against the alarm and raises the update-ended interrupt. It collects all event flags in status byte C, which clears when the host reads it. It drives a single active-high interrupt line. When the host writes a time byte outside set mode, or leaves set mode, it pulses `time_load` so that the counter reloads from the store.

Top module: `rtcreg_ctrl`

## Requirements
- R1: A write to the even address (`bus_addr`=0) stores the low 7 bits of `bus_wdata` as the index. A read of the even address returns 0xFF.
- R2: An odd-address write to an ordinary index (for example 0x45 or 0x7F) stores the byte, and an odd-address read of that index returns it.
- R3: Writes to index 12 (status C) and index 13 (D) have no effect. In index 10 (control A), bit 7 reads as the update-in-progress flag and cannot be written. Bits 6:0 of index 10 are writable.
- R4: A write to index 11 (control B) with bit 7 (set mode) high stores the byte with bit 4 (update interrupt enable) forced to 0. The same write clears the update-in-progress flag.
- R5: A read of index 12 returns the current flags. The byte then becomes 0x00 and `irq` goes low. If a new event arrives in the same cycle as the read, that event's flags and `irq` remain set afterwards.
- R6: `upd_start` sets the update-in-progress flag (A bit 7) unless B bit 7 is high. The update ends on the UPD_TICKS-th `tick_32k` after the start (8 by default), and the flag reads 0 after that edge.
- R7: When an update ends with B bit 7 low, `cur_sec`, `cur_min` and `cur_hour` are copied into indices 0, 2 and 4. With B bit 7 high, those indices keep their values.
- R8: When an update ends with B bit 5 (alarm enable) set, the alarm is checked. Each alarm byte (index 1, 3 or 5) matches if its bits 7:6 are both 1 or if it equals the corresponding time input. When all three match, C bits 7 and 5 are set and `irq` rises.
- R9: When an update ends with B bit 4 (update interrupt enable) set, C bits 7 and 4 are set and `irq` rises.
- R10: `per_strobe` sets C bits 7 and 6 and raises `irq` only while B bit 6 is set. Otherwise it leaves C and `irq` unchanged.
- R11: After `rst_n` the store reads as follows: A=0x26, B=0x02, C=0x00, D=0x80, every other byte 0x00, and `irq` is low.
- R12: A one-cycle `soft_rst` clears B bits 6, 5 and 3 and C bits 7:4, and drives `irq` low.
- R13: A write of a time byte (indices 0, 2, 4, 6 to 9) while B bit 7 is low pulses `time_load` for one cycle. A write of B that clears a set bit 7 does the same. A time-byte write in set mode gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Host access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| upd_start | input | 1 | Once-per-second update begins |
| tick_32k | input | 1 | 32768 Hz timebase strobe |
| per_strobe | input | 1 | Periodic event strobe |
| soft_rst | input | 1 | System reset pulse |
| cur_sec | input | 8 | New seconds byte |
| cur_min | input | 8 | New minutes byte |
| cur_hour | input | 8 | New hours byte |
| ctl_a | output | 7 | Control A bits 6:0 for the rate/oscillator logic |
| ctl_b | output | 8 | Control B for the time counter |
| time_load | output | 1 | Pulse: reload the time counter from the store |
| irq | output | 1 | Active-high interrupt |

## Verification
The assertions assume that `upd_start` arrives only while no update is running. They also assume that every strobe is a one-cycle pulse that is sampled on the rising edge. The bench therefore issues each update start only after the previous update has ended. It drives each strobe high for exactly one cycle, with an idle cycle between ticks. Host accesses are likewise single-cycle, so an index write and the data access that follows it never overlap.

// File: rtl/rtcreg_pkg.sv
package rtcreg_pkg;
  localparam int unsigned IX_SEC     = 0;
  localparam int unsigned IX_AL_SEC  = 1;
  localparam int unsigned IX_MIN     = 2;
  localparam int unsigned IX_AL_MIN  = 3;
  localparam int unsigned IX_HOUR    = 4;
  localparam int unsigned IX_AL_HOUR = 5;
  localparam int unsigned IX_YEAR    = 9;
  localparam int unsigned IX_CTLA    = 10;
  localparam int unsigned IX_CTLB    = 11;
  localparam int unsigned IX_STAT    = 12;
  localparam int unsigned IX_VALID   = 13;

  // control B bit positions
  localparam int unsigned B_SET  = 7;
  localparam int unsigned B_PIE  = 6;
  localparam int unsigned B_AIE  = 5;
  localparam int unsigned B_UIE  = 4;
  localparam int unsigned B_SQWE = 3;

  // status C flag masks
  localparam logic [7:0] FL_IRQ = 8'h80;
  localparam logic [7:0] FL_PER = 8'h40;
  localparam logic [7:0] FL_ALM = 8'h20;
  localparam logic [7:0] FL_UPD = 8'h10;

  localparam logic [7:0] RST_CTLA  = 8'h26;
  localparam logic [7:0] RST_CTLB  = 8'h02;
  localparam logic [7:0] RST_STAT  = 8'h00;
  localparam logic [7:0] RST_VALID = 8'h80;

  localparam logic [7:0] SOFT_B_KEEP = 8'hFF & ~((8'h1 << B_PIE) | (8'h1 << B_AIE) | (8'h1 << B_SQWE));
endpackage

// File: rtl/rtcreg_hostport.sv
module rtcreg_hostport #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [7:0]       wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             dwr_o,
  output logic             drd_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = cs_i & we_i & ~addr_i;
  assign dwr_o  = cs_i & we_i & addr_i;
  assign drd_o  = cs_i & ~we_i & addr_i;
  assign idx_o  = idx_q;

  always_comb begin
    idx_d = idx_q;
    if (idx_en) idx_d = wdata_i[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // R1: index only changes on an even-address write
  a_r1_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_i && we_i && !addr_i) |=> $stable(idx_q));
endmodule

// File: rtl/rtcreg_update_seq.sv
module rtcreg_update_seq #(
  parameter int UPD_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  input  logic set_mode_i,
  input  logic uip_clr_i,
  output logic uip_o,
  output logic end_o
);
  localparam int CNT_W = (UPD_TICKS > 1) ? $clog2(UPD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_TICKS - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             uip_q, uip_d;
  logic             launch;

  assign launch = start_i & ~busy_q;
  assign end_o  = busy_q & tick_i & (cnt_q == LAST);
  assign uip_o  = uip_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    uip_d  = uip_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      if (!set_mode_i) uip_d = 1'b1;
    end else if (busy_q && tick_i) begin
      if (end_o) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (end_o || uip_clr_i) uip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      uip_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      uip_q  <= uip_d;
    end
  end

  // R6: flag rises only from a start outside set mode
  a_r6_uip_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_q) |-> $past(start_i && !set_mode_i));
  // R6: flag is down after the update ends
  a_r6_uip_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !uip_q);
endmodule

// File: rtl/rtcreg_alarm_cmp.sv
module rtcreg_alarm_cmp #(
  parameter int N_FIELDS = 3
) (
  input  logic [N_FIELDS-1:0][7:0] alarm_i,
  input  logic [N_FIELDS-1:0][7:0] time_i,
  output logic                     hit_o
);
  logic [N_FIELDS-1:0] fld_ok;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    assign fld_ok[g] = (alarm_i[g][7:6] == 2'b11) || (alarm_i[g] == time_i[g]);
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/rtcreg_ctrl.sv
module rtcreg_ctrl
  import rtcreg_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int UPD_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_cs,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       upd_start,
  input  logic       tick_32k,
  input  logic       per_strobe,
  input  logic       soft_rst,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  output logic [6:0] ctl_a,
  output logic [7:0] ctl_b,
  output logic       time_load,
  output logic       irq
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic             dwr, drd, rd_stat;
  logic             uip, upd_end, uip_clr, alarm_hit;
  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       mem_d [DEPTH];
  logic [7:0]       flag_set;
  logic             irq_q, irq_d;
  logic             tl_q, tl_d;
  logic             set_mode;

  function automatic logic [7:0] rst_val(int unsigned i);
    case (i)
      IX_CTLA:  return RST_CTLA;
      IX_CTLB:  return RST_CTLB;
      IX_STAT:  return RST_STAT;
      IX_VALID: return RST_VALID;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic is_time_idx(int unsigned i);
    return (i == IX_SEC) || (i == IX_MIN) || (i == IX_HOUR) ||
           ((i >= 6) && (i <= IX_YEAR));
  endfunction

  rtcreg_hostport #(.IDX_W(IDX_W)) u_host (
    .clk(clk), .rst_n(rst_n), .cs_i(bus_cs), .we_i(bus_we),
    .addr_i(bus_addr), .wdata_i(bus_wdata),
    .idx_o(idx), .dwr_o(dwr), .drd_o(drd)
  );

  assign set_mode = mem_q[IX_CTLB][B_SET];
  assign uip_clr  = dwr && (int'(idx) == IX_CTLB) && bus_wdata[B_SET];
  assign rd_stat  = drd && (int'(idx) == IX_STAT);

  rtcreg_update_seq #(.UPD_TICKS(UPD_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(upd_start), .tick_i(tick_32k),
    .set_mode_i(set_mode), .uip_clr_i(uip_clr),
    .uip_o(uip), .end_o(upd_end)
  );

  rtcreg_alarm_cmp #(.N_FIELDS(3)) u_alarm (
    .alarm_i({mem_q[IX_AL_HOUR], mem_q[IX_AL_MIN], mem_q[IX_AL_SEC]}),
    .time_i ({cur_hour, cur_min, cur_sec}),
    .hit_o  (alarm_hit)
  );

  // event flags gathered this cycle
  always_comb begin
    flag_set = 8'h00;
    if (upd_end && mem_q[IX_CTLB][B_AIE] && alarm_hit) flag_set |= FL_IRQ | FL_ALM;
    if (upd_end && mem_q[IX_CTLB][B_UIE])              flag_set |= FL_IRQ | FL_UPD;
    if (per_strobe && mem_q[IX_CTLB][B_PIE])           flag_set |= FL_IRQ | FL_PER;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
    tl_d = 1'b0;
    if (upd_end && !set_mode) begin
      mem_d[IX_SEC]  = cur_sec;
      mem_d[IX_MIN]  = cur_min;
      mem_d[IX_HOUR] = cur_hour;
    end
    if (dwr) begin
      if (int'(idx) == IX_CTLA) begin
        mem_d[IX_CTLA] = {1'b0, bus_wdata[6:0]};
      end else if (int'(idx) == IX_CTLB) begin
        if (bus_wdata[B_SET]) begin
          mem_d[IX_CTLB] = bus_wdata & ~(8'h1 << B_UIE);
        end else begin
          mem_d[IX_CTLB] = bus_wdata;
          if (set_mode) tl_d = 1'b1;
        end
      end else if ((int'(idx) == IX_STAT) || (int'(idx) == IX_VALID)) begin
        mem_d[IX_STAT] = mem_q[IX_STAT];
      end else begin
        mem_d[idx] = bus_wdata;
        if (is_time_idx(int'(idx)) && !set_mode) tl_d = 1'b1;
      end
    end
    if (rd_stat) mem_d[IX_STAT] = 8'h00;
    mem_d[IX_STAT] = mem_d[IX_STAT] | flag_set;
    if (soft_rst) begin
      mem_d[IX_CTLB] = mem_d[IX_CTLB] & SOFT_B_KEEP;
      mem_d[IX_STAT] = mem_d[IX_STAT] & 8'h0F;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (rd_stat)          irq_d = 1'b0;
    if (flag_set != 8'h0) irq_d = 1'b1;
    if (soft_rst)         irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= rst_val(i);
      irq_q <= 1'b0;
      tl_q  <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      irq_q <= irq_d;
      tl_q  <= tl_d;
    end
  end

  always_comb begin
    if (!bus_addr)                    bus_rdata = 8'hFF;
    else if (int'(idx) == IX_CTLA)    bus_rdata = {uip, mem_q[IX_CTLA][6:0]};
    else                              bus_rdata = mem_q[idx];
  end

  assign ctl_a     = mem_q[IX_CTLA][6:0];
  assign ctl_b     = mem_q[IX_CTLB];
  assign time_load = tl_q;
  assign irq       = irq_q;

  // R5: the line only drops after a status read or a system reset pulse
  a_r5_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(rd_stat || soft_rst));
  // R3: low status bits never take host data
  a_r3_stat_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_q[IX_STAT][3:0] == 4'h0);
  // R4: set mode never coexists with update interrupt enable
  a_r4_set_masks_uie: assert property (@(posedge clk) disable iff (!rst_n)
    mem_q[IX_CTLB][B_SET] |-> !mem_q[IX_CTLB][B_UIE]);
  // R8: alarm flag rises only while alarms are enabled
  a_r8_alarm_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_q[IX_STAT][5]) |-> $past(mem_q[IX_CTLB][B_AIE] && upd_end));
  // R10: periodic flag rises only with periodic enable
  a_r10_per_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_q[IX_STAT][6]) |-> $past(mem_q[IX_CTLB][B_PIE] && per_strobe));
  // R12: a reset pulse leaves the line low
  a_r12_soft_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> !irq_q);
endmodule

// File: tb/rtcreg_ctrl_tb.sv
module rtcreg_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 0, bus_we = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       upd_start = 0, tick_32k = 0, per_strobe = 0, soft_rst = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0;
  logic [6:0] ctl_a;
  logic [7:0] ctl_b;
  logic       time_load, irq;

  int checks = 0, fails = 0, tl_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtcreg_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .upd_start(upd_start), .tick_32k(tick_32k), .per_strobe(per_strobe),
    .soft_rst(soft_rst), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .time_load(time_load), .irq(irq)
  );

  always @(posedge clk) if (rst_n && time_load) tl_cnt++;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_idx(logic [7:0] i);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = 0; bus_wdata = i;
    @(negedge clk); bus_cs = 0; bus_we = 0;
  endtask

  task automatic wr(logic [7:0] i, logic [7:0] d);
    wr_idx(i);
    @(negedge clk); bus_cs = 1; bus_we = 1; bus_addr = 1; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] i, output logic [7:0] d);
    wr_idx(i);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_cs = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); upd_start = 1;
    @(negedge clk); upd_start = 0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_32k = 1;
      @(negedge clk); tick_32k = 0;
    end
  endtask

  task automatic pulse_per();
    @(negedge clk); per_strobe = 1;
    @(negedge clk); per_strobe = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 irq", irq, 0);
    rd(8'd10, d); chk("R11 A", d, 8'h26);
    rd(8'd11, d); chk("R11 B", d, 8'h02);
    rd(8'd12, d); chk("R11 C", d, 8'h00);
    rd(8'd13, d); chk("R11 D", d, 8'h80);
    rd(8'h20, d); chk("R11 mem", d, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] d;
    wr(8'hC5, 8'h5A);
    rd(8'h45, d); chk("R1 index low bits", d, 8'h5A);
    wr(8'h7F, 8'h99);
    rd(8'h7F, d); chk("R2 top byte", d, 8'h99);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = 0;
    #1 d = bus_rdata;
    @(negedge clk); bus_cs = 0;
    chk("R1 even read", d, 8'hFF);
  endtask

  task automatic t_protect();
    logic [7:0] d;
    wr(8'd12, 8'hFF); rd(8'd12, d); chk("R3 C ignores write", d, 8'h00);
    wr(8'd13, 8'h00); rd(8'd13, d); chk("R3 D ignores write", d, 8'h80);
    wr(8'd10, 8'hA5); rd(8'd10, d); chk("R3 A bit7 read-only", d, 8'h25);
    wr(8'd10, 8'h26);
  endtask

  task automatic t_update();
    logic [7:0] d;
    cur_sec = 8'h30; cur_min = 8'h15; cur_hour = 8'h09;
    pulse_start();
    rd(8'd10, d); chk("R6 uip set", d, 8'hA6);
    ticks(7);
    rd(8'd10, d); chk("R6 uip before last tick", d, 8'hA6);
    ticks(1);
    rd(8'd10, d); chk("R6 uip cleared", d, 8'h26);
    rd(8'd0, d); chk("R7 sec copy", d, 8'h30);
    rd(8'd2, d); chk("R7 min copy", d, 8'h15);
    rd(8'd4, d); chk("R7 hour copy", d, 8'h09);
    rd(8'd12, d); chk("R9 no flag without UIE", d, 8'h00);
  endtask

  task automatic t_uie();
    logic [7:0] d;
    wr(8'd11, 8'h12);
    pulse_start(); ticks(8);
    chk("R9 irq raised", irq, 1);
    rd(8'd12, d); chk("R9 C flags", d, 8'h90);
    chk("R5 irq low after read", irq, 0);
    rd(8'd12, d); chk("R5 C cleared", d, 8'h00);
  endtask

  task automatic t_set();
    logic [7:0] d;
    int n0;
    wr(8'd11, 8'h02);
    pulse_start();
    rd(8'd10, d); chk("R6 uip set again", d, 8'hA6);
    wr(8'd11, 8'h92);
    rd(8'd11, d); chk("R4 UIE forced off", d, 8'h82);
    rd(8'd10, d); chk("R4 uip cleared by SET", d, 8'h26);
    cur_sec = 8'h31;
    ticks(8);
    rd(8'd0, d); chk("R7 frozen in set mode", d, 8'h30);
    pulse_start();
    rd(8'd10, d); chk("R6 no uip in set mode", d, 8'h26);
    ticks(8);
    n0 = tl_cnt;
    wr(8'd0, 8'h11);
    @(negedge clk); chk("R13 no load in set mode", tl_cnt - n0, 0);
    wr(8'd11, 8'h02);
    @(negedge clk); chk("R13 load on leaving set", tl_cnt - n0, 1);
    wr(8'd2, 8'h22);
    @(negedge clk); chk("R13 load on time write", tl_cnt - n0, 2);
  endtask

  task automatic t_alarm();
    logic [7:0] d;
    wr(8'd11, 8'h22);
    wr(8'd1, 8'h45); wr(8'd3, 8'hC0); wr(8'd5, 8'hFF);
    cur_sec = 8'h45; cur_min = 8'h16; cur_hour = 8'h09;
    pulse_start(); ticks(8);
    chk("R8 irq on match", irq, 1);
    rd(8'd12, d); chk("R8 wildcard match flags", d, 8'hA0);
    cur_sec = 8'h46;
    pulse_start(); ticks(8);
    rd(8'd12, d); chk("R8 sec mismatch", d, 8'h00);
    wr(8'd5, 8'h09); cur_sec = 8'h45;
    pulse_start(); ticks(8);
    rd(8'd12, d); chk("R8 exact hour match", d, 8'hA0);
    wr(8'd5, 8'h80);
    pulse_start(); ticks(8);
    rd(8'd12, d); chk("R8 one top bit not wildcard", d, 8'h00);
    chk("R8 irq stays low", irq, 0);
  endtask

  task automatic t_periodic();
    logic [7:0] d;
    wr(8'd11, 8'h02);
    pulse_per();
    rd(8'd12, d); chk("R10 no flag without PIE", d, 8'h00);
    chk("R10 irq low without PIE", irq, 0);
    wr(8'd11, 8'h42);
    pulse_per();
    chk("R10 irq with PIE", irq, 1);
    rd(8'd12, d); chk("R10 flags", d, 8'hC0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    pulse_per();
    wr_idx(8'd12);
    @(negedge clk); bus_cs = 1; bus_we = 0; bus_addr = 1; per_strobe = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_cs = 0; per_strobe = 0;
    chk("R5 read value", d, 8'hC0);
    chk("R5 new event keeps irq", irq, 1);
    rd(8'd12, d); chk("R5 new event keeps flags", d, 8'hC0);
  endtask

  task automatic t_softrst();
    logic [7:0] d;
    wr(8'd11, 8'h6A);
    pulse_per();
    chk("R12 irq before pulse", irq, 1);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    chk("R12 irq low", irq, 0);
    rd(8'd11, d); chk("R12 B enables cleared", d, 8'h02);
    rd(8'd12, d); chk("R12 C cleared", d, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_index();
    t_protect();
    t_update();
    t_uie();
    t_set();
    t_alarm();
    t_periodic();
    t_collide();
    t_softrst();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule